// File: doc/BRIEF.md
# Capture/Compare Channel Status and Control Register

This block holds the status and control bytes for four channels of a capture/compare timer that share one free-running counter. Each channel keeps an event flag. In capture mode the flag rises on an edge event reported by the channel's edge detector. In compare mode it rises on a match event reported by the compare logic. When the channel's interrupt enable bit is set, a raised flag drives that channel's CPU interrupt line.

Software clears a flag with a two-step handshake. It first reads the register and sees the flag at 1, then writes 0 to the flag bit. A per-channel latch remembers the qualifying read. Any event or any write to that register drops the latch. A clear therefore cannot discard an event that arrived after software last looked at the flag.

The remaining six bits are mode and edge/level settings that other timer logic decodes. This block only stores them and returns them on reads. The one exception is the two mode bits, which also choose whether the edge or the match event sets the flag.

Top module: `tmr_chan_ctrl`

## Requirements
- R1: When mode bits 5:4 of a channel are both 0 (capture mode), an `evt_edge` pulse sets the flag (bit 7) on the next clock edge, and an `evt_match` pulse is ignored.
- R2: When either mode bit 5 or 4 is 1 (compare mode), an `evt_match` pulse sets the flag on the next clock edge, and an `evt_edge` pulse is ignored.
- R3: A write with bit 7 = 0 clears the flag only if an earlier read of the same register returned the flag as 1 and no write to that register came in between. Otherwise the flag stays set. This holds whatever the interrupt enable is.
- R4: An event after the qualifying read cancels the pending clear. An event in the same cycle as the clearing write also wins, and the flag stays set.
- R5: Writing 1 to bit 7 leaves the flag unchanged, while bits 6:0 still take the written value.
- R6: `irq[n]` is 1 exactly while channel n's flag and its interrupt enable (bit 6) are both 1.
- R7: Bits 6:0 read back as written. On channels 1 and 3, bit 5 always reads 0 and ignores writes.
- R8: A synchronous reset clears every bit of all four registers, and with them all interrupt outputs.
- R9: Channel n is at address 0x13 + 3·n. A write to any other address changes nothing, and a read of any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_rd | input | 1 | Read strobe; a read that returns flag = 1 arms the clear |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| evt_edge | input | 4 | Per-channel active-edge event pulses |
| evt_match | input | 4 | Per-channel counter-match event pulses |
| irq | output | 4 | Per-channel interrupt requests |

## Verification
Configuration bytes are written to every channel with reserved, flag and control bits set in varied patterns, then read back. This separates the stored bits from the masked reserved position and from the write-protected flag. Events of both kinds are applied in each mode, which shows that the mode bits pick the right event source. The clearing write is tried in four situations: with no read before it, after a qualifying read, with an event between the read and the write, and with an event in the same cycle as the write. These cases separate a correct armed handshake from a plain write-0-clears flag. Writes and reads at an unmapped address show that the decode ignores them.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;

    localparam int NUM_CH      = 4;
    localparam int DATA_W      = 8;
    localparam int ADDR_W      = 8;
    localparam int BASE_ADDR   = 'h13;
    localparam int ADDR_STRIDE = 3;

    typedef struct packed {
        logic flag;
        logic irq_en;
        logic mode_b;
        logic mode_a;
        logic edge_b;
        logic edge_a;
        logic tog_ovf;
        logic max_duty;
    } chan_reg_t;

    // Odd channels have no mode_b storage.
    function automatic logic mode_b_present(input int ch);
        return (ch % 2) == 0;
    endfunction

    function automatic logic is_capture(input chan_reg_t r);
        return !r.mode_b && !r.mode_a;
    endfunction

    function automatic logic [ADDR_W-1:0] chan_addr(input int base, input int stride, input int ch);
        return ADDR_W'(base + ch * stride);
    endfunction

endpackage

// File: rtl/tmr_chan_dec.sv
module tmr_chan_dec
    import tmr_chan_pkg::*;
#(
    parameter int N_CH   = NUM_CH,
    parameter int BASE   = BASE_ADDR,
    parameter int STRIDE = ADDR_STRIDE
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [N_CH-1:0]   sel
);
    for (genvar i = 0; i < N_CH; i++) begin : g_cmp
        assign sel[i] = (addr == chan_addr(BASE, STRIDE, i));
    end
endmodule

// File: rtl/tmr_chan_slot.sv
module tmr_chan_slot
    import tmr_chan_pkg::*;
#(
    parameter bit HAS_MODE_B = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_hit,
    input  logic              rd_hit,
    input  logic [DATA_W-1:0] wdata,
    input  logic              evt_edge,
    input  logic              evt_match,
    output chan_reg_t         reg_q
);
    chan_reg_t reg_d;
    logic      armed_q, armed_d;
    logic      evt_hit;

    assign evt_hit = is_capture(reg_q) ? evt_edge : evt_match;

    always_comb begin
        reg_d   = reg_q;
        armed_d = armed_q;
        if (wr_hit) begin
            reg_d = chan_reg_t'({reg_q.flag, wdata[DATA_W-2:0]});
            if (!HAS_MODE_B) reg_d.mode_b = 1'b0;
            if (!wdata[DATA_W-1] && armed_q) reg_d.flag = 1'b0;
            armed_d = 1'b0;
        end else if (rd_hit && reg_q.flag) begin
            armed_d = 1'b1;
        end
        // A new event outranks any clear in flight.
        if (evt_hit) begin
            reg_d.flag = 1'b1;
            armed_d    = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_q   <= '0;
            armed_q <= 1'b0;
        end else begin
            reg_q   <= reg_d;
            armed_q <= armed_d;
        end
    end

    AST_EVT_SETS_FLAG:   assert property (@(posedge clk) disable iff (rst) evt_hit |=> reg_q.flag); // R1
    AST_CLEAR_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst) $fell(reg_q.flag) |-> ($past(armed_q) && $past(wr_hit))); // R3
    AST_EVT_DISARMS:     assert property (@(posedge clk) disable iff (rst) (armed_q && evt_hit) |=> !armed_q); // R4
    AST_WR1_KEEPS_FLAG:  assert property (@(posedge clk) disable iff (rst) (wr_hit && wdata[DATA_W-1] && reg_q.flag) |=> reg_q.flag); // R5
endmodule

// File: rtl/tmr_chan_ctrl.sv
module tmr_chan_ctrl
    import tmr_chan_pkg::*;
#(
    parameter int N_CH   = NUM_CH,
    parameter int BASE   = BASE_ADDR,
    parameter int STRIDE = ADDR_STRIDE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N_CH-1:0]   evt_edge,
    input  logic [N_CH-1:0]   evt_match,
    output logic [N_CH-1:0]   irq
);
    logic [N_CH-1:0] sel;
    chan_reg_t       regs [N_CH];

    tmr_chan_dec #(.N_CH(N_CH), .BASE(BASE), .STRIDE(STRIDE)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        tmr_chan_slot #(.HAS_MODE_B(mode_b_present(i))) u_slot (
            .clk       (clk),
            .rst       (rst),
            .wr_hit    (bus_wr && sel[i]),
            .rd_hit    (bus_rd && sel[i]),
            .wdata     (bus_wdata),
            .evt_edge  (evt_edge[i]),
            .evt_match (evt_match[i]),
            .reg_q     (regs[i])
        );
        assign irq[i] = regs[i].flag && regs[i].irq_en;
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < N_CH; i++) begin
            if (sel[i]) bus_rdata = bus_rdata | regs[i];
        end
    end

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(sel)); // R9
endmodule

// File: tb/tb_tmr_chan_ctrl.sv
module tb_tmr_chan_ctrl;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] bus_addr;
    logic       bus_rd, bus_wr;
    logic [7:0] bus_wdata, bus_rdata;
    logic [3:0] evt_edge, evt_match, irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    tmr_chan_ctrl dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_edge(evt_edge),
        .evt_match(evt_match), .irq(irq)
    );

    localparam int NV = 8;
    localparam logic [1:0] V_CH  [NV] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd0, 2'd1, 2'd2, 2'd3};
    localparam logic [7:0] V_WR  [NV] = '{8'h3F, 8'h3F, 8'hA5, 8'h2A, 8'h15, 8'hFF, 8'h00, 8'h7F};
    localparam logic [7:0] V_EXP [NV] = '{8'h3F, 8'h1F, 8'h25, 8'h0A, 8'h15, 8'h5F, 8'h00, 8'h5F};

    function automatic logic [7:0] adr(input int ch);
        return 8'(8'h13 + 3 * ch);
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic pulse(input int ch, input bit is_match);
        @(negedge clk);
        if (is_match) evt_match[ch] = 1'b1; else evt_edge[ch] = 1'b1;
        @(negedge clk);
        evt_match = '0; evt_edge = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] d;
        rst = 1'b1; bus_addr = '0; bus_rd = 0; bus_wr = 0; bus_wdata = '0;
        evt_edge = '0; evt_match = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R8: reset state
        for (int c = 0; c < 4; c++) begin
            rd(adr(c), d); check("R8 reset value", d, 8'h00);
        end
        check("R8 irq after reset", {4'h0, irq}, 8'h00);

        // R7/R5: configuration table
        for (int v = 0; v < NV; v++) begin
            wr(adr(V_CH[v]), V_WR[v]);
            rd(adr(V_CH[v]), d);
            check("R7 readback", d, V_EXP[v]);
            check("R6 irq idle", {4'h0, irq}, 8'h00);
        end

        // ch3 is now compare mode with enable: raise a flag, then reset
        pulse(3, 1'b1);
        check("R2 ch3 match irq", {4'h0, irq}, 8'h08);
        do_reset();
        check("R8 irq cleared by reset", {4'h0, irq}, 8'h00);
        for (int c = 0; c < 4; c++) begin
            rd(adr(c), d); check("R8 value after reset", d, 8'h00);
        end

        // R1: capture mode on ch0
        wr(adr(0), 8'h40);
        pulse(0, 1'b1);
        check("R1 match ignored in capture", {4'h0, irq}, 8'h00);
        pulse(0, 1'b0);
        check("R1 edge sets flag", {4'h0, irq}, 8'h01);
        // R3: write 0 without read
        wr(adr(0), 8'h40);
        check("R3 unarmed clear ignored", {4'h0, irq}, 8'h01);
        rd(adr(0), d);
        check("R3 read shows flag", d, 8'hC0);
        wr(adr(0), 8'h40);
        check("R3 armed clear", {4'h0, irq}, 8'h00);

        // R4: event between read and write
        pulse(0, 1'b0);
        rd(adr(0), d);
        pulse(0, 1'b0);
        wr(adr(0), 8'h40);
        check("R4 event cancels clear", {4'h0, irq}, 8'h01);
        // R4: event in same cycle as clearing write
        rd(adr(0), d);
        @(negedge clk);
        bus_addr = adr(0); bus_wdata = 8'h40; bus_wr = 1'b1; evt_edge[0] = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; evt_edge = '0;
        check("R4 same-cycle event wins", {4'h0, irq}, 8'h01);

        // R5: writing 1 to flag
        rd(adr(0), d);
        wr(adr(0), 8'hC0);
        check("R5 write 1 keeps flag", {4'h0, irq}, 8'h01);
        wr(adr(0), 8'h40);
        check("R3 write disarms", {4'h0, irq}, 8'h01);
        rd(adr(0), d);
        wr(adr(0), 8'h00);
        rd(adr(0), d);
        check("R3 cleared and disabled", d, 8'h00);

        // R2: compare mode on ch2
        wr(adr(2), 8'h50);
        pulse(2, 1'b0);
        check("R2 edge ignored in compare", {4'h0, irq}, 8'h00);
        pulse(2, 1'b1);
        check("R2 match sets flag", {4'h0, irq}, 8'h04);
        rd(adr(2), d);
        check("R2 readback", d, 8'hD0);

        // R6: enable gates irq
        wr(adr(2), 8'h90);
        check("R6 irq off when disabled", {4'h0, irq}, 8'h00);
        rd(adr(2), d);
        check("R6 flag still set", d, 8'h90);
        wr(adr(2), 8'hD0);
        check("R6 irq back on", {4'h0, irq}, 8'h04);

        // R9: unmapped address
        wr(8'h14, 8'hFF);
        wr(8'h00, 8'h00);
        rd(8'h14, d);
        check("R9 unmapped read", d, 8'h00);
        rd(8'h1D, d);
        check("R9 unmapped read high", d, 8'h00);
        rd(adr(2), d);
        check("R9 ch2 untouched", d, 8'hD0);
        rd(adr(1), d);
        check("R9 ch1 untouched", d, 8'h00);
        check("R9 irq untouched", {4'h0, irq}, 8'h04);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule